// File: doc/BRIEF.md
# Open-Page DRAM Command Scheduler

This block drives the command bus of one DRAM channel shared by several banks. Read and write requests arrive already split into bank, row and column. They wait in an eight-entry queue that keeps their arrival order. The scheduler remembers which row each bank holds open and leaves rows open after an access. Each cycle it picks one queued request. A request whose row is already open in its bank wins over any request that is not. Among requests of the same kind, the one that arrived first wins. The scheduler then puts the single command that request needs next on the bus: a column read or write when the row is open, an activate when the bank is closed, or a precharge when another row occupies the bank.

Simple per-bank delay counters gate the commands. A bank takes no column command until the activate-to-column delay has passed. It takes no activate until the precharge delay has passed. After a refresh, no bank takes any command until the refresh delay has passed. A free-running interval timer raises a refresh demand. While the demand is pending, the scheduler stops serving the queue and closes every open bank. It then issues one refresh and goes back to normal work. A read-data strobe follows each read by a fixed column latency.

Top module: `dram_sched`

## Requirements
- R1: Command codes on cmdKind are 0 idle, 1 activate, 2 read, 3 write, 4 precharge and 5 refresh. After reset the bus is idle, the queue is empty, all banks are closed, reqReady is high and rdValid is low.
- R2: A request is taken on a clock edge where reqValid and reqReady are both high. reqReady is low exactly when 8 requests are queued. A request offered while reqReady is low is not taken.
- R3: When any queued request targets the row open in its bank, the scheduler serves the first-arrived such request ahead of all other requests, including older ones.
- R4: When no queued request hits an open row, the first-arrived request is selected. The bank and column on the bus belong to the selected request.
- R5: For the selected request, a closed bank gets an activate that carries the request's row. A bank holding a different row gets a precharge. The column command only goes to a bank whose requested row is open, and it removes the request from the queue.
- R6: A column command to a bank comes at least T_RCD cycles after that bank's activate. An activate comes at least T_RP cycles after that bank's precharge. If the selected request's bank is still waiting, the bus stays idle that cycle.
- R7: A row stays open after a column access. A later request to the same row gets its column command with no new activate or precharge.
- R8: rdValid is high exactly T_CL cycles after each read command and never follows a write.
- R9: A refresh demand is raised every T_REFI cycles. While it is pending, no queued request is served. Open banks are precharged one per cycle, lowest ready bank first. Refresh is issued only when all banks are closed and their delays have elapsed.
- R10: For T_RFC-1 cycles after a refresh command, the bus stays idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | A request is offered |
| reqReady | output | 1 | Queue has a free slot |
| reqWrite | input | 1 | 1 for write, 0 for read |
| reqBank | input | BANK_W | Target bank |
| reqRow | input | ROW_W | Target row |
| reqCol | input | COL_W | Target column |
| cmdKind | output | 3 | Command code of this cycle (R1) |
| cmdBank | output | BANK_W | Bank of an activate, read, write or precharge |
| cmdRow | output | ROW_W | Row, meaningful with an activate |
| cmdCol | output | COL_W | Column, meaningful with a read or write |
| rdValid | output | 1 | Read data valid strobe |

## Verification
The bound checker watches every cycle for several rules. It flags a column command to a closed bank or an activate to an open one, and a breach of the activate-to-column or precharge-to-activate spacing. It also flags a refresh with any bank open, a command inside the post-refresh quiet window, a ready flag that disagrees with the queue fill level, and a read strobe that no earlier read accounts for. Some properties can only be judged by following the whole queue: whether a hit really beat older misses, whether the oldest miss was chosen, which bank gets precharged first during refresh, and the exact cycle of each strobe. The bench's scenarios show these, using a behavioural reference that predicts every command.

// File: rtl/dram_sched_pkg.sv
package dram_sched_pkg;

  typedef enum logic [2:0] {
    CMD_IDLE = 3'd0,
    CMD_ACT  = 3'd1,
    CMD_RD   = 3'd2,
    CMD_WR   = 3'd3,
    CMD_PRE  = 3'd4,
    CMD_REF  = 3'd5
  } cmd_e;

  // strobes from control to datapath
  typedef struct packed {
    logic doDeq;    // remove selected entry
    logic doOpen;   // mark bank open with selected row
    logic doClose;  // mark bank closed
  } strobe_t;

endpackage

// File: rtl/dram_sched_dp.sv
module dram_sched_dp
  import dram_sched_pkg::*;
#(
  parameter int NB    = 4,
  parameter int DEPTH = 8,
  parameter int ROW_W = 8,
  parameter int COL_W = 6,
  localparam int BANK_W = (NB > 1) ? $clog2(NB) : 1,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic                              enq,
  input  logic                              enqWrite,
  input  logic [BANK_W-1:0]                 enqBank,
  input  logic [ROW_W-1:0]                  enqRow,
  input  logic [COL_W-1:0]                  enqCol,
  input  strobe_t                           strobe,
  input  logic [BANK_W-1:0]                 stBank,
  input  logic [IDX_W-1:0]                  selIdx,
  output logic [CNT_W-1:0]                  count,
  output logic [DEPTH-1:0]                  entWrite,
  output logic [DEPTH-1:0]                  entHit,
  output logic [DEPTH-1:0][BANK_W-1:0]      entBank,
  output logic [DEPTH-1:0][ROW_W-1:0]       entRow,
  output logic [DEPTH-1:0][COL_W-1:0]       entCol,
  output logic [NB-1:0]                     bankOpen
);

  logic [NB-1:0][ROW_W-1:0]    rowTab;
  logic [DEPTH-1:0]            nWrite;
  logic [DEPTH-1:0][BANK_W-1:0] nBank;
  logic [DEPTH-1:0][ROW_W-1:0] nRow;
  logic [DEPTH-1:0][COL_W-1:0] nCol;
  logic [CNT_W-1:0]            cntAfter, nCount;

  // age-ordered queue: slot 0 is oldest; removal compacts, arrival appends
  always_comb begin
    nWrite   = entWrite;
    nBank    = entBank;
    nRow     = entRow;
    nCol     = entCol;
    cntAfter = count;
    if (strobe.doDeq) begin
      for (int i = 0; i < DEPTH - 1; i++) begin
        if (IDX_W'(i) >= selIdx) begin
          nWrite[i] = entWrite[i+1];
          nBank[i]  = entBank[i+1];
          nRow[i]   = entRow[i+1];
          nCol[i]   = entCol[i+1];
        end
      end
      cntAfter = count - CNT_W'(1);
    end
    for (int i = 0; i < DEPTH; i++) begin
      if (enq && (CNT_W'(i) == cntAfter)) begin
        nWrite[i] = enqWrite;
        nBank[i]  = enqBank;
        nRow[i]   = enqRow;
        nCol[i]   = enqCol;
      end
    end
    nCount = cntAfter + CNT_W'(enq);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count    <= '0;
      entWrite <= '0;
      entBank  <= '0;
      entRow   <= '0;
      entCol   <= '0;
    end else begin
      count    <= nCount;
      entWrite <= nWrite;
      entBank  <= nBank;
      entRow   <= nRow;
      entCol   <= nCol;
    end
  end

  // per-bank open-row table
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bankOpen <= '0;
      rowTab   <= '0;
    end else if (strobe.doOpen) begin
      bankOpen[stBank] <= 1'b1;
      rowTab[stBank]   <= entRow[selIdx];
    end else if (strobe.doClose) begin
      bankOpen[stBank] <= 1'b0;
    end
  end

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      entHit[i] = (CNT_W'(i) < count) && bankOpen[entBank[i]] &&
                  (rowTab[entBank[i]] == entRow[i]);
    end
  end

endmodule

// File: rtl/dram_sched_ctrl.sv
module dram_sched_ctrl
  import dram_sched_pkg::*;
#(
  parameter int NB     = 4,
  parameter int DEPTH  = 8,
  parameter int ROW_W  = 8,
  parameter int COL_W  = 6,
  parameter int T_RCD  = 3,
  parameter int T_RP   = 2,
  parameter int T_CL   = 4,
  parameter int T_RFC  = 6,
  parameter int T_REFI = 400,
  localparam int BANK_W = (NB > 1) ? $clog2(NB) : 1,
  localparam int IDX_W  = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1),
  localparam int T_AB   = (T_RCD > T_RP) ? T_RCD : T_RP,
  localparam int T_MAX  = (T_AB > T_RFC) ? T_AB : T_RFC,
  localparam int WAIT_W = $clog2(T_MAX + 1),
  localparam int REFI_W = $clog2(T_REFI + 1)
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [CNT_W-1:0]             count,
  input  logic [DEPTH-1:0]             entWrite,
  input  logic [DEPTH-1:0]             entHit,
  input  logic [DEPTH-1:0][BANK_W-1:0] entBank,
  input  logic [DEPTH-1:0][ROW_W-1:0]  entRow,
  input  logic [DEPTH-1:0][COL_W-1:0]  entCol,
  input  logic [NB-1:0]                bankOpen,
  output strobe_t                      strobe,
  output logic [BANK_W-1:0]            cmdBank,
  output logic [IDX_W-1:0]             selIdx,
  output cmd_e                         cmdKind,
  output logic [ROW_W-1:0]             cmdRow,
  output logic [COL_W-1:0]             cmdCol,
  output logic                         rdValid
);

  logic [WAIT_W-1:0] waitCnt [NB];
  logic [NB-1:0]     bankReady;
  logic [IDX_W-1:0]  hitIdx;
  logic              preFound;
  logic [BANK_W-1:0] preBank, selBank;
  logic              refPending;
  logic [REFI_W-1:0] refTimer;
  logic [T_CL-1:0]   rdPipe;

  always_comb begin
    for (int b = 0; b < NB; b++) bankReady[b] = (waitCnt[b] == '0);
    hitIdx = '0;
    for (int i = DEPTH - 1; i >= 0; i--) if (entHit[i]) hitIdx = IDX_W'(i);
    preFound = 1'b0;
    preBank  = '0;
    for (int b = NB - 1; b >= 0; b--) begin
      if (bankOpen[b] && bankReady[b]) begin
        preFound = 1'b1;
        preBank  = BANK_W'(b);
      end
    end
  end

  assign selIdx  = hitIdx;  // oldest hit, else slot 0 (oldest overall)
  assign selBank = entBank[selIdx];
  assign cmdRow  = entRow[selIdx];
  assign cmdCol  = entCol[selIdx];

  always_comb begin
    cmdKind = CMD_IDLE;
    cmdBank = selBank;
    strobe  = '0;
    if (refPending) begin
      cmdBank = preBank;
      if (|bankOpen) begin
        if (preFound) begin
          cmdKind        = CMD_PRE;
          strobe.doClose = 1'b1;
        end
      end else if (&bankReady) begin
        cmdKind = CMD_REF;
      end
    end else if ((count != '0) && bankReady[selBank]) begin
      if (entHit[selIdx]) begin
        cmdKind      = entWrite[selIdx] ? CMD_WR : CMD_RD;
        strobe.doDeq = 1'b1;
      end else if (bankOpen[selBank]) begin
        cmdKind        = CMD_PRE;
        strobe.doClose = 1'b1;
      end else begin
        cmdKind       = CMD_ACT;
        strobe.doOpen = 1'b1;
      end
    end
  end

  for (genvar b = 0; b < NB; b++) begin : g_bankWait
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        waitCnt[b] <= '0;
      else if (cmdKind == CMD_REF)
        waitCnt[b] <= WAIT_W'(T_RFC - 1);
      else if ((cmdBank == BANK_W'(b)) && (cmdKind == CMD_ACT))
        waitCnt[b] <= WAIT_W'(T_RCD - 1);
      else if ((cmdBank == BANK_W'(b)) && (cmdKind == CMD_PRE))
        waitCnt[b] <= WAIT_W'(T_RP - 1);
      else if (waitCnt[b] != '0)
        waitCnt[b] <= waitCnt[b] - WAIT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      refTimer   <= '0;
      refPending <= 1'b0;
      rdPipe     <= '0;
    end else begin
      if (cmdKind == CMD_REF) refPending <= 1'b0;
      if (refTimer == REFI_W'(T_REFI - 1)) begin
        refTimer   <= '0;
        refPending <= 1'b1;
      end else begin
        refTimer <= refTimer + REFI_W'(1);
      end
      rdPipe <= T_CL'({rdPipe, (cmdKind == CMD_RD)});
    end
  end

  assign rdValid = rdPipe[T_CL-1];

endmodule

// File: rtl/dram_sched.sv
module dram_sched
  import dram_sched_pkg::*;
#(
  parameter int NB     = 4,
  parameter int DEPTH  = 8,
  parameter int ROW_W  = 8,
  parameter int COL_W  = 6,
  parameter int T_RCD  = 3,
  parameter int T_RP   = 2,
  parameter int T_CL   = 4,
  parameter int T_RFC  = 6,
  parameter int T_REFI = 400,
  localparam int BANK_W = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [BANK_W-1:0] reqBank,
  input  logic [ROW_W-1:0]  reqRow,
  input  logic [COL_W-1:0]  reqCol,
  output logic [2:0]        cmdKind,
  output logic [BANK_W-1:0] cmdBank,
  output logic [ROW_W-1:0]  cmdRow,
  output logic [COL_W-1:0]  cmdCol,
  output logic              rdValid
);

  localparam int IDX_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic                         enq;
  logic [CNT_W-1:0]             count;
  logic [DEPTH-1:0]             entWrite, entHit;
  logic [DEPTH-1:0][BANK_W-1:0] entBank;
  logic [DEPTH-1:0][ROW_W-1:0]  entRow;
  logic [DEPTH-1:0][COL_W-1:0]  entCol;
  logic [NB-1:0]                bankOpen;
  strobe_t                      strobe;
  logic [IDX_W-1:0]             selIdx;
  cmd_e                         kind;

  assign reqReady = (count < CNT_W'(DEPTH));
  assign enq      = reqValid && reqReady;
  assign cmdKind  = kind;

  dram_sched_dp #(.NB(NB), .DEPTH(DEPTH), .ROW_W(ROW_W), .COL_W(COL_W)) u_dp (
    .clk(clk), .rstN(rstN), .enq(enq), .enqWrite(reqWrite), .enqBank(reqBank),
    .enqRow(reqRow), .enqCol(reqCol), .strobe(strobe), .stBank(cmdBank),
    .selIdx(selIdx), .count(count), .entWrite(entWrite), .entHit(entHit),
    .entBank(entBank), .entRow(entRow), .entCol(entCol), .bankOpen(bankOpen)
  );

  dram_sched_ctrl #(
    .NB(NB), .DEPTH(DEPTH), .ROW_W(ROW_W), .COL_W(COL_W), .T_RCD(T_RCD),
    .T_RP(T_RP), .T_CL(T_CL), .T_RFC(T_RFC), .T_REFI(T_REFI)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .count(count), .entWrite(entWrite), .entHit(entHit),
    .entBank(entBank), .entRow(entRow), .entCol(entCol), .bankOpen(bankOpen),
    .strobe(strobe), .cmdBank(cmdBank), .selIdx(selIdx), .cmdKind(kind),
    .cmdRow(cmdRow), .cmdCol(cmdCol), .rdValid(rdValid)
  );

endmodule

// File: rtl/dram_sched_chk.sv
module dram_sched_chk
  import dram_sched_pkg::*;
#(
  parameter int NB     = 4,
  parameter int DEPTH  = 8,
  parameter int T_RCD  = 3,
  parameter int T_RP   = 2,
  parameter int T_RFC  = 6,
  localparam int BANK_W = (NB > 1) ? $clog2(NB) : 1
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic [2:0]        cmdKind,
  input logic [BANK_W-1:0] cmdBank,
  input logic              rdValid
);

  localparam int SAT = 1000;

  logic [NB-1:0] openMap;
  int sinceAct [NB];
  int sincePre [NB];
  int sinceRef, qLevel, rdPend;
  logic isCol;

  assign isCol = (cmdKind == CMD_RD) || (cmdKind == CMD_WR);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      openMap  <= '0;
      sinceRef <= SAT;
      qLevel   <= 0;
      rdPend   <= 0;
      for (int b = 0; b < NB; b++) begin
        sinceAct[b] <= SAT;
        sincePre[b] <= SAT;
      end
    end else begin
      for (int b = 0; b < NB; b++) begin
        if (cmdKind == CMD_ACT && cmdBank == BANK_W'(b)) sinceAct[b] <= 1;
        else if (sinceAct[b] < SAT) sinceAct[b] <= sinceAct[b] + 1;
        if (cmdKind == CMD_PRE && cmdBank == BANK_W'(b)) sincePre[b] <= 1;
        else if (sincePre[b] < SAT) sincePre[b] <= sincePre[b] + 1;
      end
      if (cmdKind == CMD_ACT) openMap[cmdBank] <= 1'b1;
      if (cmdKind == CMD_PRE) openMap[cmdBank] <= 1'b0;
      sinceRef <= (cmdKind == CMD_REF) ? 1 : ((sinceRef < SAT) ? sinceRef + 1 : sinceRef);
      qLevel   <= qLevel + ((reqValid && reqReady) ? 1 : 0) - (isCol ? 1 : 0);
      rdPend   <= rdPend + ((cmdKind == CMD_RD) ? 1 : 0) - (rdValid ? 1 : 0);
    end
  end

  // R6
  col_spacing_chk: assert property (@(posedge clk) disable iff (!rstN)
    isCol |-> sinceAct[cmdBank] >= T_RCD);
  // R6
  act_spacing_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdKind == CMD_ACT) |-> sincePre[cmdBank] >= T_RP);
  // R5
  col_open_chk: assert property (@(posedge clk) disable iff (!rstN)
    isCol |-> openMap[cmdBank]);
  // R5
  act_closed_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdKind == CMD_ACT) |-> !openMap[cmdBank]);
  // R9
  ref_closed_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdKind == CMD_REF) |-> (openMap == '0));
  // R10
  ref_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRef < T_RFC) |-> (cmdKind == CMD_IDLE));
  // R2
  ready_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqReady == (qLevel < DEPTH));
  // R8
  rd_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> rdPend > 0);

endmodule

bind dram_sched dram_sched_chk #(
  .NB(NB), .DEPTH(DEPTH), .T_RCD(T_RCD), .T_RP(T_RP), .T_RFC(T_RFC)
) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .cmdKind(cmdKind), .cmdBank(cmdBank), .rdValid(rdValid)
);

// File: tb/test_dram_sched.sv
module test_dram_sched;

  localparam int CLK_PERIOD = 10;
  localparam int NB = 4, DEPTH = 8, ROW_W = 8, COL_W = 6;
  localparam int T_RCD = 3, T_RP = 2, T_CL = 4, T_RFC = 6, T_REFI = 400;
  localparam int BANK_W = $clog2(NB);
  localparam int WATCHDOG = 50000;

  logic clk = 1'b0, rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [BANK_W-1:0] reqBank = '0;
  logic [ROW_W-1:0]  reqRow = '0;
  logic [COL_W-1:0]  reqCol = '0;
  logic reqReady, rdValid;
  logic [2:0] cmdKind;
  logic [BANK_W-1:0] cmdBank;
  logic [ROW_W-1:0]  cmdRow;
  logic [COL_W-1:0]  cmdCol;

  dram_sched #(.NB(NB), .DEPTH(DEPTH), .ROW_W(ROW_W), .COL_W(COL_W), .T_RCD(T_RCD),
               .T_RP(T_RP), .T_CL(T_CL), .T_RFC(T_RFC), .T_REFI(T_REFI)) i_dram_sched (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady), .reqWrite(reqWrite),
    .reqBank(reqBank), .reqRow(reqRow), .reqCol(reqCol), .cmdKind(cmdKind),
    .cmdBank(cmdBank), .cmdRow(cmdRow), .cmdCol(cmdCol), .rdValid(rdValid));

  always #(CLK_PERIOD / 2) clk = ~clk;

  int vectors = 0, miscompares = 0, cycles = 0;
  bit running = 1'b0, done = 1'b0;

  // behavioural reference state
  int qBank[$], qRow[$], qCol[$], qWr[$];
  bit mOpen [NB];
  int mRow  [NB];
  int mWait [NB];
  int mTimer = 0, sinceRef = 1000;
  bit mPend = 1'b0;
  bit [31:0] mHist = '0;

  task automatic check(string tag, string what, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  // predict, compare and advance the reference once per cycle
  always @(negedge clk) begin
    int eKind, eBank, eRow, eCol, sel, pb, bk;
    bit anyHit, anyOpen, allIdle, enq;
    string tag;
    if (running && !done) begin
      cycles++;
      eKind = 0; eBank = 0; eRow = 0; eCol = 0; sel = 0; anyHit = 0;
      for (int i = qBank.size() - 1; i >= 0; i--)
        if (mOpen[qBank[i]] && mRow[qBank[i]] == qRow[i]) begin anyHit = 1; sel = i; end
      if (mPend) begin
        anyOpen = 0; allIdle = 1; pb = -1;
        for (int b = NB - 1; b >= 0; b--) begin
          if (mOpen[b]) anyOpen = 1;
          if (mWait[b] != 0) allIdle = 0;
          if (mOpen[b] && mWait[b] == 0) pb = b;
        end
        if (anyOpen) begin
          if (pb >= 0) begin eKind = 4; eBank = pb; end
        end else if (allIdle) eKind = 5;
      end else if (qBank.size() > 0) begin
        bk = qBank[sel];
        if (mWait[bk] == 0) begin
          eBank = bk;
          if (anyHit) begin eKind = qWr[sel] ? 3 : 2; eCol = qCol[sel]; end
          else if (mOpen[bk]) eKind = 4;
          else begin eKind = 1; eRow = qRow[sel]; end
        end
      end
      // tag the command check by the rule that decides it
      if (mPend || eKind == 5) tag = "R9";
      else if (sinceRef < T_RFC) tag = "R10";
      else if (eKind == 2 || eKind == 3) tag = "R3";
      else if (eKind == 1 || eKind == 4) tag = "R5";
      else tag = "R6";
      check(tag, "cmdKind", int'(cmdKind), eKind);
      if (eKind >= 1 && eKind <= 4) check("R4", "cmdBank", int'(cmdBank), eBank);
      if (eKind == 1) check("R5", "cmdRow", int'(cmdRow), eRow);
      if (eKind == 2 || eKind == 3) check("R4", "cmdCol", int'(cmdCol), eCol);
      check("R2", "reqReady", int'(reqReady), (qBank.size() < DEPTH) ? 1 : 0);
      check("R8", "rdValid", int'(rdValid), int'(mHist[T_CL-1]));

      enq = reqValid && (qBank.size() < DEPTH);
      if (eKind == 2 || eKind == 3) begin
        qBank.delete(sel); qRow.delete(sel); qCol.delete(sel); qWr.delete(sel);
      end
      if (enq) begin
        qBank.push_back(int'(reqBank)); qRow.push_back(int'(reqRow));
        qCol.push_back(int'(reqCol)); qWr.push_back(int'(reqWrite));
      end
      for (int b = 0; b < NB; b++) begin
        if (eKind == 5) mWait[b] = T_RFC - 1;
        else if (eKind == 1 && b == eBank) begin mWait[b] = T_RCD - 1; mOpen[b] = 1; mRow[b] = eRow; end
        else if (eKind == 4 && b == eBank) begin mWait[b] = T_RP - 1; mOpen[b] = 0; end
        else if (mWait[b] > 0) mWait[b]--;
      end
      if (eKind == 5) mPend = 0;
      if (mTimer == T_REFI - 1) begin mTimer = 0; mPend = 1; end
      else mTimer++;
      mHist = {mHist[30:0], (eKind == 2)};
      sinceRef = (eKind == 5) ? 1 : sinceRef + 1;
    end
  end

  task automatic put(bit w, int b, int r, int c);
    bit acc;
    reqValid = 1'b1; reqWrite = w;
    reqBank = BANK_W'(b); reqRow = ROW_W'(r); reqCol = COL_W'(c);
    acc = 1'b0;
    while (!acc) begin
      @(negedge clk); acc = reqReady;
      @(posedge clk); #1;
    end
  endtask

  task automatic idle(int n);
    reqValid = 1'b0;
    repeat (n) begin @(posedge clk); #1; end
  endtask

  initial begin
    int seed;
    for (int b = 0; b < NB; b++) begin mOpen[b] = 0; mRow[b] = 0; mWait[b] = 0; end
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    running = 1'b1;
    @(negedge clk);
    // R1: idle bus, ready, no read strobe after reset
    check("R1", "cmdKind after reset", int'(cmdKind), 0);
    check("R1", "reqReady after reset", int'(reqReady), 1);
    check("R1", "rdValid after reset", int'(rdValid), 0);
    @(posedge clk); #1;

    // R5 R6 R8: read to closed bank, activate then column after delay
    put(0, 0, 5, 1); idle(12);
    // R7: same row again, column with no activate
    put(0, 0, 5, 2); idle(8);
    // R5: row conflict in bank 0, precharge then activate
    put(1, 0, 9, 3); idle(12);
    // R3: older miss to bank 2, then a hit to bank 0 row 9
    put(0, 2, 3, 4); put(0, 0, 9, 5); put(1, 0, 9, 6); idle(16);
    // R4: misses to several closed banks, oldest first
    put(0, 1, 7, 7); put(0, 3, 8, 8); put(1, 1, 2, 9); put(0, 3, 1, 10); idle(30);
    // R2: burst of conflicts on one bank fills the queue
    for (int i = 0; i < 14; i++) put(i % 2, 1, 20 + i, i);
    idle(80);
    // R9 R10: banks left open across a refresh interval
    put(0, 2, 40, 1); put(0, 3, 41, 2); idle(T_REFI + 40);
    // mixed stream across further refreshes, exercising all rules
    seed = 7;
    for (int i = 0; i < 400; i++) begin
      seed = seed * 1103515245 + 12345;
      put((seed >>> 7) & 1, (seed >>> 9) & (NB - 1), (seed >>> 12) & 3, (seed >>> 16) & 63);
      if (((seed >>> 20) & 7) == 0) idle(3);
    end
    idle(200);
    report();
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      vectors++; miscompares++;
      $display("FAIL R2 watchdog: cycles %0d expected below %0d", cycles, WATCHDOG);
      report();
    end
  end

endmodule